// File: doc/BRIEF.md
# Register-mapped random generator controller

This block puts a pseudo-random generation core behind a simple 32-bit register bus. Software seeds the generator by writing a reseed command, then asks for fresh random blocks by writing a generate command. It learns that an operation has finished either by polling two busy bits in the status register or by enabling an interrupt. Each completed generate leaves a block of eight 32-bit result words in a read window. A mode bit picks how much of that block software sees: 128 bits, which is the first four words, or 256 bits, which is all eight.

The generation core is a 32-bit Galois LFSR and stands in for a real entropy source. A reseed loads the LFSR from the `entropy_i` input. If the LFSR would ever be left at all zeros, it is forced to a fixed nonzero fill value and a lockup flag is raised. Generation and reseed each take a fixed number of cycles, set by parameters. Commands that arrive at the wrong moment are dropped.

Reads return data on `bus_rdata` one clock after `bus_rd`. Writes take effect at the clock edge that samples `bus_wr`.

Top module: `randgen_ctrl`

## Requirements
- R1: After reset the following all read zero: status, mode, secure-mode, interrupt enable, interrupt status and every result word. `irq_o` is low after reset.
- R2: Register map: 0x00 command (reads 0), 0x04 status (read-only), 0x08 mode (only bit 3 is stored), 0x0C secure-mode (only bit 8 is stored), 0x10 interrupt enable (bits 0, 1, 4 and 31 are stored). Unstored bits read 0. Status bit 3 mirrors mode bit 3, and status bit 8 mirrors secure-mode bit 8.
- R3: Writing 2 to 0x00 while idle starts a reseed. Status bit 31 is set for exactly SEED_CYCLES (32) cycles. After that, `entropy_i` is loaded into the LFSR, status bit 9 (seeded) sets and stays set, and interrupt status bit 1 sets.
- R4: Writing 1 to 0x00 while idle and seeded starts a generate. Status bit 30 is set for exactly GEN_CYCLES (16) cycles. After that, all eight result words at 0x20..0x3C update at once to nonzero values, and interrupt status bit 0 sets.
- R5: A generate command written before any reseed has completed is ignored: no busy bit, no flag, and the result words are unchanged.
- R6: While either busy bit is set, every command is ignored. Command values other than 1 and 2 are always ignored.
- R7: The result words depend only on the seed last loaded and on how many generates have run since then. Reseeding with the same value and generating again reproduces the same eight words, and two successive generates give different blocks.
- R8: When mode bit 3 is clear, words 4..7 (0x30..0x3C) read 0 and words 0..3 read normally. Changing the mode does not alter the stored words.
- R9: Interrupt status at 0x14 has ready at bit 0, reseed done at bit 1 and lockup at bit 4. Writing a 1 to a bit clears it, writing a 0 leaves it, and a new event in the same cycle wins over the clear.
- R10: `irq_o` is high exactly when enable bit 31 is set and at least one interrupt status bit is pending whose enable bit (same position) is set.
- R11: If the LFSR would become all zeros, it is loaded with LOCK_FILL (default 32'h1D2C_3B4A) instead, and interrupt status bit 4 sets. Reseeding with 0 therefore produces the same results as reseeding with LOCK_FILL, but only the zero seed raises bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| entropy_i | input | 32 | Seed value sampled when a reseed completes |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench measures the busy windows to the exact cycle from the command write. A counter that is off by one would show up as a busy bit one sample too long or too short.

It fires commands into the middle of running operations and before the first seed, and issues unsupported command codes. A design that accepted any of these would raise an unexpected ready or reseed-done flag, or stay busy.

It seeds the generator with zero and compares the results against a seed equal to the fill constant. A missing lockup substitution would either freeze the results at zero or change them, and a missing flag would leave bit 4 clear.

It checks partial write-one-to-clear on several pending flags, and checks that the interrupt stays low without the global enable. Wrong masking would either clear flags that were not targeted or raise `irq_o` with no enabled source pending.

// File: rtl/randgen_pkg.sv
package randgen_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_MODE  = 8'h08;
  localparam logic [7:0] OFS_SMODE = 8'h0C;
  localparam logic [7:0] OFS_IE    = 8'h10;
  localparam logic [7:0] OFS_ISTAT = 8'h14;
  localparam logic [7:0] OFS_WORD0 = 8'h20;

  localparam logic [31:0] CMD_GEN  = 32'd1;
  localparam logic [31:0] CMD_SEED = 32'd2;

  localparam int B_WIDE      = 3;
  localparam int B_MISSION   = 8;
  localparam int B_SEEDED    = 9;
  localparam int B_GEN_BUSY  = 30;
  localparam int B_SEED_BUSY = 31;
  localparam int B_GLBL      = 31;

  // interrupt sources, in the order used by the flag vector
  localparam int N_SRC = 3;
  localparam int SRC_RDY   = 0;
  localparam int SRC_SDONE = 1;
  localparam int SRC_LOCK  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_GEN  = 2'd1,
    SQ_SEED = 2'd2
  } seq_state_e;
endpackage

// File: rtl/randgen_seq.sv
module randgen_seq
  import randgen_pkg::*;
#(
  parameter int GEN_CYCLES  = 16,
  parameter int SEED_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic req_gen,
  input  logic req_seed,
  output logic gen_busy,
  output logic seed_busy,
  output logic seeded,
  output logic gen_commit,
  output logic seed_load,
  output logic gen_done,
  output logic seed_done
);
  localparam int MAXC = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] GEN_LAST  = CW'(GEN_CYCLES - 1);
  localparam logic [CW-1:0] SEED_LAST = CW'(SEED_CYCLES - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      seeded    <= 1'b0;
      gen_done  <= 1'b0;
      seed_done <= 1'b0;
    end else begin
      gen_done  <= 1'b0;
      seed_done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (req_seed)               state <= SQ_SEED;
          else if (req_gen && seeded) state <= SQ_GEN;
        end
        SQ_GEN: begin
          if (cnt == GEN_LAST) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            gen_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_SEED: begin
          if (cnt == SEED_LAST) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            seeded    <= 1'b1;
            seed_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign gen_busy   = (state == SQ_GEN);
  assign seed_busy  = (state == SQ_SEED);
  assign gen_commit = gen_busy && (cnt == GEN_LAST);
  assign seed_load  = seed_busy && (cnt == SEED_LAST);

  AST_GEN_NEEDS_SEED: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && req_gen && !req_seed && !seeded) |=> (state == SQ_IDLE)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (gen_busy && !gen_commit) |=> gen_busy); // R6
  AST_SEEDED_STICKY: assert property (@(posedge clk) disable iff (rst)
    seeded |=> seeded); // R3
  AST_DONE_AFTER_GEN: assert property (@(posedge clk) disable iff (rst)
    $rose(gen_done) |-> $past(gen_busy)); // R4
endmodule

// File: rtl/randgen_pool.sv
module randgen_pool #(
  parameter int          W         = 32,
  parameter int          WORDS     = 8,
  parameter logic [W-1:0] TAPS     = 32'h8020_0003,
  parameter logic [W-1:0] LOCK_FILL = 32'h1D2C_3B4A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gen_step,
  input  logic         gen_commit,
  input  logic         seed_load,
  input  logic [W-1:0] entropy,
  output logic         lockup,
  output logic [W-1:0] res [WORDS]
);
  logic [W-1:0] lfsr;
  logic [W-1:0] stepped;
  logic [W-1:0] cand;
  logic [W-1:0] stage [WORDS];

  always_comb begin
    stepped = lfsr >> 1;
    if (lfsr[0]) stepped = stepped ^ TAPS;
    if (seed_load)     cand = entropy;
    else if (gen_step) cand = stepped;
    else               cand = lfsr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr   <= LOCK_FILL;
      lockup <= 1'b0;
    end else begin
      lockup <= 1'b0;
      if (cand == '0) begin
        lfsr   <= LOCK_FILL;
        lockup <= 1'b1;
      end else begin
        lfsr <= cand;
      end
    end
  end

  // staging shift line filled during generation, committed in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stage[0] <= '0;
      res[0]   <= '0;
    end else begin
      if (gen_step)   stage[0] <= lfsr;
      if (gen_commit) res[0]   <= lfsr;
    end
  end

  for (genvar g = 1; g < WORDS; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[g] <= '0;
        res[g]   <= '0;
      end else begin
        if (gen_step)   stage[g] <= stage[g-1];
        if (gen_commit) res[g]   <= stage[g-1];
      end
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0); // R11
  AST_LOCK_FILL: assert property (@(posedge clk) disable iff (rst)
    lockup |-> (lfsr == LOCK_FILL)); // R11
endmodule

// File: rtl/randgen_irq.sv
module randgen_irq
  import randgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_set,
  input  logic             ie_we,
  input  logic             istat_we,
  input  logic [31:0]      wdata,
  output logic [N_SRC-1:0] istat_q,
  output logic [N_SRC-1:0] ie_q,
  output logic             glbl_q,
  output logic             irq_o
);
  localparam int SRC_BIT [N_SRC] = '{0, 1, 4};

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        istat_q[g] <= 1'b0;
        ie_q[g]    <= 1'b0;
      end else begin
        if (src_set[g])                          istat_q[g] <= 1'b1;
        else if (istat_we && wdata[SRC_BIT[g]])  istat_q[g] <= 1'b0;
        if (ie_we) ie_q[g] <= wdata[SRC_BIT[g]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glbl_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (ie_we) glbl_q <= wdata[B_GLBL];
      irq_o <= glbl_q && |(istat_q & ie_q);
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (istat_we && wdata[0] && !src_set[SRC_RDY]) |=> !istat_q[SRC_RDY]); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    src_set[SRC_RDY] |=> istat_q[SRC_RDY]); // R9
  AST_IRQ_NEEDS_GLBL: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(glbl_q)); // R10
endmodule

// File: rtl/randgen_ctrl.sv
module randgen_ctrl
  import randgen_pkg::*;
#(
  parameter int          GEN_CYCLES  = 16,
  parameter int          SEED_CYCLES = 32,
  parameter int          WORDS       = 8,
  parameter logic [31:0] TAPS        = 32'h8020_0003,
  parameter logic [31:0] LOCK_FILL   = 32'h1D2C_3B4A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] entropy_i,
  output logic        irq_o
);
  localparam int WIDX    = $clog2(WORDS);
  localparam int NARROW  = WORDS / 2;
  localparam int WIN_END = 32 + 4 * WORDS;

  logic sel_ctrl, sel_stat, sel_mode, sel_smode, sel_ie, sel_istat, hit_word;
  logic [WIDX-1:0] idx;
  logic            word_visible;

  assign sel_ctrl  = (bus_addr == OFS_CTRL);
  assign sel_stat  = (bus_addr == OFS_STAT);
  assign sel_mode  = (bus_addr == OFS_MODE);
  assign sel_smode = (bus_addr == OFS_SMODE);
  assign sel_ie    = (bus_addr == OFS_IE);
  assign sel_istat = (bus_addr == OFS_ISTAT);
  assign hit_word  = (bus_addr >= OFS_WORD0) && ({24'd0, bus_addr} < 32'(WIN_END));
  assign idx       = bus_addr[WIDX+1:2];

  logic mode_wide, mission;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wide <= 1'b0;
      mission   <= 1'b0;
    end else if (bus_wr) begin
      if (sel_mode)  mode_wide <= bus_wdata[B_WIDE];
      if (sel_smode) mission   <= bus_wdata[B_MISSION];
    end
  end

  assign word_visible = mode_wide || (int'(idx) < NARROW);

  logic req_gen, req_seed;
  assign req_gen  = bus_wr && sel_ctrl && (bus_wdata == CMD_GEN);
  assign req_seed = bus_wr && sel_ctrl && (bus_wdata == CMD_SEED);

  logic gen_busy, seed_busy, seeded, gen_commit, seed_load, gen_done, seed_done;
  logic lockup;
  logic [31:0] res [WORDS];

  randgen_seq #(
    .GEN_CYCLES (GEN_CYCLES),
    .SEED_CYCLES(SEED_CYCLES)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .req_gen   (req_gen),
    .req_seed  (req_seed),
    .gen_busy  (gen_busy),
    .seed_busy (seed_busy),
    .seeded    (seeded),
    .gen_commit(gen_commit),
    .seed_load (seed_load),
    .gen_done  (gen_done),
    .seed_done (seed_done)
  );

  randgen_pool #(
    .W        (32),
    .WORDS    (WORDS),
    .TAPS     (TAPS),
    .LOCK_FILL(LOCK_FILL)
  ) i_pool (
    .clk       (clk),
    .rst       (rst),
    .gen_step  (gen_busy),
    .gen_commit(gen_commit),
    .seed_load (seed_load),
    .entropy   (entropy_i),
    .lockup    (lockup),
    .res       (res)
  );

  logic [N_SRC-1:0] src_set, istat_q, ie_q;
  logic             glbl_q;

  always_comb begin
    src_set            = '0;
    src_set[SRC_RDY]   = gen_done;
    src_set[SRC_SDONE] = seed_done;
    src_set[SRC_LOCK]  = lockup;
  end

  randgen_irq i_irq (
    .clk     (clk),
    .rst     (rst),
    .src_set (src_set),
    .ie_we   (bus_wr && sel_ie),
    .istat_we(bus_wr && sel_istat),
    .wdata   (bus_wdata),
    .istat_q (istat_q),
    .ie_q    (ie_q),
    .glbl_q  (glbl_q),
    .irq_o   (irq_o)
  );

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sel_stat) begin
      rd_mux[B_WIDE]      = mode_wide;
      rd_mux[B_MISSION]   = mission;
      rd_mux[B_SEEDED]    = seeded;
      rd_mux[B_GEN_BUSY]  = gen_busy;
      rd_mux[B_SEED_BUSY] = seed_busy;
    end else if (sel_mode) begin
      rd_mux[B_WIDE] = mode_wide;
    end else if (sel_smode) begin
      rd_mux[B_MISSION] = mission;
    end else if (sel_ie) begin
      rd_mux[0]      = ie_q[SRC_RDY];
      rd_mux[1]      = ie_q[SRC_SDONE];
      rd_mux[4]      = ie_q[SRC_LOCK];
      rd_mux[B_GLBL] = glbl_q;
    end else if (sel_istat) begin
      rd_mux[0] = istat_q[SRC_RDY];
      rd_mux[1] = istat_q[SRC_SDONE];
      rd_mux[4] = istat_q[SRC_LOCK];
    end else if (hit_word && word_visible) begin
      rd_mux = res[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_NARROW_HIDES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_word && !mode_wide && (int'(idx) >= NARROW)) |=> (bus_rdata == '0)); // R8
  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    !(gen_busy && seed_busy)); // R6
endmodule

// File: tb/test_randgen_ctrl.sv
module test_randgen_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FILL = 32'h1D2C_3B4A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] entropy_i = '0;
  logic        irq_o;

  randgen_ctrl i_randgen_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .entropy_i(entropy_i),
    .irq_o    (irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(8'h04, s);
      if (s[31:30] == 2'b00) break;
    end
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] cur [8];
  task automatic grab();
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(i * 4), cur[i]);
  endtask

  typedef struct packed {
    logic [7:0]  a;
    logic        w;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h08, 1'b1, 32'hFFFF_FFFF, 32'h0000_0008},
    '{8'h0C, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100},
    '{8'h10, 1'b1, 32'hFFFF_FFFF, 32'h8000_0013},
    '{8'h04, 1'b1, 32'hFFFF_FFFF, 32'h0000_0108},
    '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    '{8'h04, 1'b0, 32'h0000_0000, 32'h0000_0108},
    '{8'h08, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{8'h04, 1'b0, 32'h0000_0000, 32'h0000_0100},
    '{8'h10, 1'b1, 32'h8000_0002, 32'h8000_0002},
    '{8'h10, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{8'h0C, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{8'h04, 1'b0, 32'h0000_0000, 32'h0000_0000}
  };

  logic [31:0] v;
  logic [31:0] w1 [8];
  logic [31:0] wz [8];

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h04, v); chk("R1 status", v, 32'h0);
    rd(8'h08, v); chk("R1 mode", v, 32'h0);
    rd(8'h0C, v); chk("R1 smode", v, 32'h0);
    rd(8'h10, v); chk("R1 ie", v, 32'h0);
    rd(8'h14, v); chk("R1 istat", v, 32'h0);
    rd(8'h20, v); chk("R1 word0", v, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);

    // R5 generate before seeding
    wr(8'h00, 32'd1);
    rd(8'h04, v); chk("R5 no busy", v, 32'h0);
    repeat (20) @(negedge clk);
    rd(8'h14, v); chk("R5 no flag", v, 32'h0);
    rd(8'h20, v); chk("R5 words unchanged", v, 32'h0);

    // R2 register map table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, v);
      chk($sformatf("R2 vec%0d", i), v, VEC[i].e);
    end

    // R3 reseed timing
    entropy_i = 32'h1234_5678;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'd2);
    repeat (30) @(negedge clk);
    rd(8'h04, v); chk("R3 seed busy last cycle", v, 32'h8000_0008);
    repeat (1) @(negedge clk);
    rd(8'h04, v); chk("R3 seeded idle", v, 32'h0000_0208);
    repeat (2) @(negedge clk);
    rd(8'h14, v); chk("R3 seed done flag", v, 32'h2);
    wr(8'h14, 32'h2);

    // R4 generate timing
    wr(8'h00, 32'd1);
    repeat (14) @(negedge clk);
    rd(8'h04, v); chk("R4 gen busy last cycle", v, 32'h4000_0208);
    repeat (1) @(negedge clk);
    rd(8'h04, v); chk("R4 gen idle", v, 32'h0000_0208);
    repeat (2) @(negedge clk);
    rd(8'h14, v); chk("R4 ready flag", v, 32'h1);
    grab();
    for (int i = 0; i < 8; i++) begin
      w1[i] = cur[i];
      chk($sformatf("R4 word%0d nonzero", i), {31'd0, cur[i] != 32'h0}, 32'h1);
    end

    // R7 determinism
    wr(8'h00, 32'd1); wait_idle();
    grab();
    chk("R7 next block differs", {31'd0, cur[0] != w1[0]}, 32'h1);
    wr(8'h00, 32'd2); wait_idle();
    wr(8'h00, 32'd1); wait_idle();
    grab();
    for (int i = 0; i < 8; i++) chk($sformatf("R7 replay word%0d", i), cur[i], w1[i]);

    // R8 narrow window
    wr(8'h08, 32'h0);
    rd(8'h04, v); chk("R8 status mirror clear", v, 32'h200);
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(i * 4), v);
      chk($sformatf("R8 narrow word%0d", i), v, (i < 4) ? w1[i] : 32'h0);
    end
    wr(8'h08, 32'h8);
    rd(8'h3C, v); chk("R8 word7 restored", v, w1[7]);

    // R6 commands while busy or unsupported
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd2);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'd1);
    wait_idle();
    rd(8'h14, v); chk("R6 gen during seed ignored", v, 32'h2);
    rd(8'h20, v); chk("R6 words kept", v, w1[0]);
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1);
    repeat (3) @(negedge clk);
    wr(8'h00, 32'd2);
    wait_idle();
    rd(8'h14, v); chk("R6 seed during gen ignored", v, 32'h1);
    wr(8'h00, 32'd3);
    rd(8'h04, v); chk("R6 code 3 ignored", v, 32'h208);
    wr(8'h14, 32'h13);

    // R11 lockup on zero seed, R9 partial clears
    entropy_i = 32'h0;
    wr(8'h00, 32'd2); wait_idle();
    rd(8'h14, v); chk("R11 lockup and seed flags", v, 32'h12);
    wr(8'h00, 32'd1); wait_idle();
    rd(8'h14, v); chk("R9 three pending", v, 32'h13);
    grab();
    for (int i = 0; i < 8; i++) wz[i] = cur[i];
    wr(8'h14, 32'h2);
    rd(8'h14, v); chk("R9 clear one bit", v, 32'h11);
    wr(8'h14, 32'h11);
    rd(8'h14, v); chk("R9 clear read value", v, 32'h0);
    entropy_i = FILL;
    wr(8'h00, 32'd2); wait_idle();
    wr(8'h00, 32'd1); wait_idle();
    rd(8'h14, v); chk("R11 fill seed no lockup", v, 32'h3);
    grab();
    for (int i = 0; i < 8; i++) chk($sformatf("R11 fill word%0d", i), cur[i], wz[i]);

    // R10 interrupt gating (ready and seed-done pending)
    wr(8'h10, 32'h0000_0001); repeat (2) @(negedge clk);
    chk("R10 no global", {31'd0, irq_o}, 32'h0);
    wr(8'h10, 32'h8000_0001); repeat (2) @(negedge clk);
    chk("R10 ready enabled", {31'd0, irq_o}, 32'h1);
    wr(8'h14, 32'h1); repeat (2) @(negedge clk);
    chk("R10 cleared source", {31'd0, irq_o}, 32'h0);
    wr(8'h10, 32'h8000_0002); repeat (2) @(negedge clk);
    chk("R10 seed done enabled", {31'd0, irq_o}, 32'h1);
    wr(8'h10, 32'h8000_0010); repeat (2) @(negedge clk);
    chk("R10 only lockup enabled", {31'd0, irq_o}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule